// File: doc/BRIEF.md
# Table-Assisted Sine/Cosine Phase Converter

This block turns a phase word coming out of a direct digital synthesizer's phase accumulator into a pair of signed amplitude samples, one sine and one cosine. It accepts a new phase on every clock and gives one sample pair per clock at a fixed pipeline depth. It has no iterative rotation loop.

The two top phase bits choose a quadrant. The next bits address a small first-quadrant table, which holds sine and cosine at the centre of each segment. The lowest bits are recoded into a signed offset from that centre, and this offset drives a single small-angle correction: sin ≈ S + C·δ and cos ≈ C − S·δ. The constant radians-per-step factor is applied as a fixed multiply. Quadrant symmetry then restores the signs and swaps sine and cosine where the quadrant needs it.

With the default parameters, a 16-bit phase maps to 14-bit two's-complement outputs. The peak amplitude is 8190, and a 64-entry table stands in for a 16384-entry quarter-wave table.

Top module: `phase_to_sincos`

## Requirements
- R1: While `rst_n` is low, `amp_valid` is 0 and `sin_out` and `cos_out` are both 0.
- R2: `amp_valid` is asserted exactly 4 rising clock edges after the edge that sampled `phase_valid` high, and is low otherwise. A phase presented on every cycle yields a sample on every cycle.
- R3: For an accepted phase p, angle a = 2π·p/65536. Each output stays within 2 LSB of the real-valued model: `sin_out` ≈ 8190·sin(a) and `cos_out` ≈ 8190·cos(a).
- R4: Neither output ever takes the most negative code, -8192.
- R5: Phase bits [15:14] give the quadrant. Adding 16384 to a phase gives exactly `sin_out` = previous `cos_out` and `cos_out` = negated previous `sin_out`.
- R6: While `amp_valid` is low, `sin_out` and `cos_out` keep the last produced pair, whatever `phase` carries.
- R7: A phase with bits [15:14] = 00 yields `sin_out` ≥ 0 and `cos_out` ≥ 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_valid | input | 1 | Phase word is valid this cycle |
| phase | input | 16 | Unsigned phase, full circle = 65536 |
| amp_valid | output | 1 | Sample pair valid |
| sin_out | output | 14 | Signed sine sample |
| cos_out | output | 14 | Signed cosine sample |

## Verification
Every result is due four rising edges after the edge that accepts its phase, and this holds for valid, sine and cosine alike. The bench drives inputs on the falling edge and keeps a four-entry record of what it drove. On each later falling edge it compares the outputs with the entry driven four falling edges before. On cycles whose record is empty it expects `amp_valid` low and the previous pair held. The quadrant-identity checks use phases sent on consecutive cycles, so each result is compared with the result produced one cycle earlier.

// File: rtl/p2a_pkg.sv
package p2a_pkg;

  typedef enum logic [1:0] {QUAD_0, QUAD_1, QUAD_2, QUAD_3} quad_e;

  // radians covered by one phase step inside a quadrant
  function automatic real quad_step(input int phase_w);
    return 1.5707963267948966 / (2.0 ** (phase_w - 2));
  endfunction

  // arithmetic shift right with round-half-up
  function automatic longint rnd_shr(input longint v, input int sh);
    return (v + (longint'(1) <<< (sh - 1))) >>> sh;
  endfunction

  // small-angle correction: amp * delta * step, step held as kq / 2^sh
  function automatic longint fine_corr(input longint amp, input longint d,
                                       input longint kq, input int sh);
    return rnd_shr(amp * d * kq, sh);
  endfunction

endpackage

// File: rtl/p2a_coarse_rom.sv
module p2a_coarse_rom #(
  parameter int PHASE_W = 16,
  parameter int IDX_W   = 6,
  parameter int OUT_W   = 14,
  parameter int GUARD   = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               en,
  input  logic [IDX_W-1:0]                   idx,
  output logic signed [OUT_W+GUARD-1:0]      sin_c,
  output logic signed [OUT_W+GUARD-1:0]      cos_c
);
  localparam int  TW     = OUT_W + GUARD;
  localparam int  DEPTH  = 2 ** IDX_W;
  localparam int  FINE_W = PHASE_W - 2 - IDX_W;
  localparam int  SEG    = 2 ** FINE_W;
  localparam real STEP   = p2a_pkg::quad_step(PHASE_W);
  localparam real SCALE  = real'(2 ** (OUT_W - 1) - 2) * (2.0 ** GUARD);

  logic signed [TW-1:0] sin_tab [DEPTH];
  logic signed [TW-1:0] cos_tab [DEPTH];

  // entries sit at the centre of each segment
  for (genvar g = 0; g < DEPTH; g++) begin : g_tab
    localparam real ANG = (real'(g) * real'(SEG) + real'(SEG / 2)) * STEP;
    localparam int  SV  = $rtoi(SCALE * $sin(ANG) + 0.5);
    localparam int  CV  = $rtoi(SCALE * $cos(ANG) + 0.5);
    assign sin_tab[g] = TW'(SV);
    assign cos_tab[g] = TW'(CV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_c <= '0;
      cos_c <= '0;
    end else if (en) begin
      sin_c <= sin_tab[idx];
      cos_c <= cos_tab[idx];
    end
  end
endmodule

// File: rtl/p2a_fine_rot.sv
module p2a_fine_rot #(
  parameter int PHASE_W = 16,
  parameter int IDX_W   = 6,
  parameter int OUT_W   = 14,
  parameter int GUARD   = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               en,
  input  logic signed [OUT_W+GUARD-1:0]      sin_c,
  input  logic signed [OUT_W+GUARD-1:0]      cos_c,
  input  logic signed [PHASE_W-3-IDX_W:0]    delta,
  output logic signed [OUT_W+GUARD:0]        sin_f,
  output logic signed [OUT_W+GUARD:0]        cos_f
);
  localparam int     TW   = OUT_W + GUARD;
  localparam int     KSH  = PHASE_W + 8;
  localparam real    STEP = p2a_pkg::quad_step(PHASE_W);
  localparam longint KQ   = longint'($rtoi(STEP * (2.0 ** KSH) + 0.5));

  longint corr_s, corr_c;

  always_comb begin
    corr_s = p2a_pkg::fine_corr(longint'(cos_c), longint'(delta), KQ, KSH);
    corr_c = p2a_pkg::fine_corr(longint'(sin_c), longint'(delta), KQ, KSH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_f <= '0;
      cos_f <= '0;
    end else if (en) begin
      sin_f <= (TW+1)'(longint'(sin_c) + corr_s);
      cos_f <= (TW+1)'(longint'(cos_c) - corr_c);
    end
  end
endmodule

// File: rtl/p2a_quadrant_fold.sv
module p2a_quadrant_fold #(
  parameter int OUT_W = 14,
  parameter int GUARD = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  p2a_pkg::quad_e                quad,
  input  logic signed [OUT_W+GUARD:0]   sin_f,
  input  logic signed [OUT_W+GUARD:0]   cos_f,
  output logic signed [OUT_W-1:0]       sin_o,
  output logic signed [OUT_W-1:0]       cos_o
);
  longint rs, rc, ns, nc;

  always_comb begin
    rs = p2a_pkg::rnd_shr(longint'(sin_f), GUARD);
    rc = p2a_pkg::rnd_shr(longint'(cos_f), GUARD);
    case (quad)
      p2a_pkg::QUAD_1: begin ns = rc;  nc = -rs; end
      p2a_pkg::QUAD_2: begin ns = -rs; nc = -rc; end
      p2a_pkg::QUAD_3: begin ns = -rc; nc = rs;  end
      default:         begin ns = rs;  nc = rc;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_o <= '0;
      cos_o <= '0;
    end else if (en) begin
      sin_o <= OUT_W'(ns);
      cos_o <= OUT_W'(nc);
    end
  end
endmodule

// File: rtl/phase_to_sincos.sv
module phase_to_sincos #(
  parameter int PHASE_W = 16,
  parameter int IDX_W   = 6,
  parameter int OUT_W   = 14,
  parameter int GUARD   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     phase_valid,
  input  logic [PHASE_W-1:0]       phase,
  output logic                     amp_valid,
  output logic signed [OUT_W-1:0]  sin_out,
  output logic signed [OUT_W-1:0]  cos_out
);
  import p2a_pkg::*;

  localparam int FINE_W = PHASE_W - 2 - IDX_W;
  localparam int TW     = OUT_W + GUARD;

  logic                     v1, v2, v3, v4;
  quad_e                    q1, q2, q3;
  logic [IDX_W-1:0]         idx1;
  logic signed [FINE_W-1:0] d1, d2;
  logic signed [TW-1:0]     s_coarse, c_coarse;
  logic signed [TW:0]       s_fine, c_fine;

  // recoding: offset from segment centre = fine bits with MSB inverted
  wire [FINE_W-1:0] fine_bits = phase[FINE_W-1:0];
  wire signed [FINE_W-1:0] delta_recoded = {~fine_bits[FINE_W-1], fine_bits[FINE_W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0;
      q1 <= QUAD_0; q2 <= QUAD_0; q3 <= QUAD_0;
      idx1 <= '0; d1 <= '0; d2 <= '0;
    end else begin
      v1 <= phase_valid;
      v2 <= v1;
      v3 <= v2;
      v4 <= v3;
      if (phase_valid) begin
        q1   <= quad_e'(phase[PHASE_W-1 -: 2]);
        idx1 <= phase[PHASE_W-3 -: IDX_W];
        d1   <= delta_recoded;
      end
      if (v1) begin
        q2 <= q1;
        d2 <= d1;
      end
      if (v2) q3 <= q2;
    end
  end

  p2a_coarse_rom #(.PHASE_W(PHASE_W), .IDX_W(IDX_W), .OUT_W(OUT_W), .GUARD(GUARD)) u_rom (
    .clk(clk), .rst_n(rst_n), .en(v1), .idx(idx1),
    .sin_c(s_coarse), .cos_c(c_coarse));

  p2a_fine_rot #(.PHASE_W(PHASE_W), .IDX_W(IDX_W), .OUT_W(OUT_W), .GUARD(GUARD)) u_fine (
    .clk(clk), .rst_n(rst_n), .en(v2), .sin_c(s_coarse), .cos_c(c_coarse),
    .delta(d2), .sin_f(s_fine), .cos_f(c_fine));

  p2a_quadrant_fold #(.OUT_W(OUT_W), .GUARD(GUARD)) u_fold (
    .clk(clk), .rst_n(rst_n), .en(v3), .quad(q3),
    .sin_f(s_fine), .cos_f(c_fine), .sin_o(sin_out), .cos_o(cos_out));

  assign amp_valid = v4;
endmodule

// File: rtl/p2a_checker.sv
module p2a_checker #(
  parameter int PHASE_W = 16,
  parameter int OUT_W   = 14
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     phase_valid,
  input logic [PHASE_W-1:0]       phase,
  input logic                     amp_valid,
  input logic signed [OUT_W-1:0]  sin_out,
  input logic signed [OUT_W-1:0]  cos_out
);
  localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!amp_valid && sin_out == '0 && cos_out == '0));

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd5) |-> (amp_valid == $past(phase_valid, 4)));

  p_no_most_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    amp_valid |-> (sin_out != MOST_NEG && cos_out != MOST_NEG));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd1 && !amp_valid) |-> ($stable(sin_out) && $stable(cos_out)));

  p_first_quad_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd5 && amp_valid && $past(phase[PHASE_W-1 -: 2], 4) == 2'b00)
      |-> (sin_out >= 0 && cos_out >= 0));
endmodule

bind phase_to_sincos p2a_checker #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_p2a_checker (
  .clk(clk), .rst_n(rst_n), .phase_valid(phase_valid), .phase(phase),
  .amp_valid(amp_valid), .sin_out(sin_out), .cos_out(cos_out));

// File: tb/phase_to_sincos_test.sv
module phase_to_sincos_test;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               phase_valid = 1'b0;
  logic [15:0]        phase = '0;
  logic               amp_valid;
  logic signed [13:0] sin_out, cos_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int exp_v [4];
  int exp_p [4];
  int held_s = 0, held_c = 0;
  bit have_prev = 0;
  int prev_p = 0, prev_s = 0, prev_c = 0;

  always #4 clk = ~clk;

  phase_to_sincos uut (.clk(clk), .rst_n(rst_n), .phase_valid(phase_valid), .phase(phase),
                       .amp_valid(amp_valid), .sin_out(sin_out), .cos_out(cos_out));

  function automatic real ref_sin(input int p);
    return 8190.0 * $sin(6.283185307179586 * real'(p) / 65536.0);
  endfunction
  function automatic real ref_cos(input int p);
    return 8190.0 * $cos(6.283185307179586 * real'(p) / 65536.0);
  endfunction
  function automatic real absr(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic check_out();
    int s, c, p;
    s = int'(sin_out);
    c = int'(cos_out);
    if (exp_v[3] != 0) begin
      p = exp_p[3];
      check(amp_valid == 1'b1, "R2", $sformatf("valid actual=%0d expected=1 phase=%0d", amp_valid, p));
      check(absr(real'(s) - ref_sin(p)) <= 2.0, "R3",
            $sformatf("sin phase=%0d actual=%0d expected=%f", p, s, ref_sin(p)));
      check(absr(real'(c) - ref_cos(p)) <= 2.0, "R3",
            $sformatf("cos phase=%0d actual=%0d expected=%f", p, c, ref_cos(p)));
      check(s != -8192 && c != -8192, "R4",
            $sformatf("phase=%0d actual=%0d/%0d expected=not -8192", p, s, c));
      if (p < 16384)
        check(s >= 0 && c >= 0, "R7",
              $sformatf("phase=%0d actual=%0d/%0d expected=both >= 0", p, s, c));
      if (have_prev && p == ((prev_p + 16384) % 65536))
        check(s == prev_c && c == -prev_s, "R5",
              $sformatf("phase=%0d actual=%0d/%0d expected=%0d/%0d", p, s, c, prev_c, -prev_s));
      have_prev = 1;
      prev_p = p; prev_s = s; prev_c = c;
      held_s = s; held_c = c;
    end else begin
      check(amp_valid == 1'b0, "R2", $sformatf("valid actual=%0d expected=0", amp_valid));
      check(s == held_s && c == held_c, "R6",
            $sformatf("hold actual=%0d/%0d expected=%0d/%0d", s, c, held_s, held_c));
      have_prev = 0;
    end
  endtask

  task automatic cycle(input bit v, input int p);
    @(negedge clk);
    check_out();
    for (int i = 3; i > 0; i--) begin
      exp_v[i] = exp_v[i-1];
      exp_p[i] = exp_p[i-1];
    end
    exp_v[0] = v;
    exp_p[0] = p;
    phase_valid = v;
    phase = 16'(p);
  endtask

  initial begin
    int base;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin exp_v[i] = 0; exp_p[i] = 0; end
    // R1: reset state, with phase inputs toggling
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      phase_valid = 1'b1;
      phase = 16'(i * 7919);
      check(amp_valid == 1'b0 && sin_out == 0 && cos_out == 0, "R1",
            $sformatf("reset actual=%0d/%0d/%0d expected=0/0/0", amp_valid, sin_out, cos_out));
    end
    @(negedge clk);
    phase_valid = 1'b0;
    rst_n = 1'b1;
    // directed corners: quadrant edges, segment edges
    cycle(1, 0);     cycle(1, 16384); cycle(1, 32768); cycle(1, 49152);
    cycle(1, 65535); cycle(1, 255);   cycle(1, 256);   cycle(1, 16383);
    cycle(0, 12345); cycle(0, 4321);
    cycle(1, 128);   cycle(1, 16512);
    for (int i = 0; i < 6; i++) cycle(0, 999);
    // R3: full sweep, one phase per cycle
    for (int p = 0; p < 65536; p++) cycle(1, p);
    // R2/R6: random valid gaps with random phases
    for (int i = 0; i < 3000; i++) cycle(($urandom % 10) < 6, $urandom % 65536);
    // R5: quadrant rotations on consecutive cycles
    for (int i = 0; i < 300; i++) begin
      base = $urandom % 16384;
      cycle(1, base); cycle(1, base + 16384); cycle(1, base + 32768); cycle(1, base + 49152);
      if (($urandom % 4) == 0) cycle(0, $urandom % 65536);
    end
    for (int i = 0; i < 6; i++) cycle(0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule